// File: doc/BRIEF.md
# Address Window Forwarding Decoder

This block sits in a memory fabric switch or host bridge and decides, for every memory request, which downstream port carries it. It holds a small bank of programmable windows. Each window has a base, a length, a downstream port number and a commit bit. A request whose address falls inside a committed window goes out on that window's port. The address is passed through untouched, because a forwarding hop never translates it.

A request that hits no committed window is not sent on any port. Instead it raises a one-cycle unrouted flag. Several windows may point at the same port. This lets one device's capacity be split across separate regions with an unmapped gap between them. Windows are aligned to 256 MB granules and are written through a simple register write port. Decoding takes one cycle. A valid/ready handshake is used on the request side and on every downstream port.

Top module: `addr_route_dec`

## Requirements
- R1: A forwarded request carries on `fwd_addr` exactly the 52-bit address that was accepted; no bit is altered.
- R2: Window bounds are counted in 256 MB granules, compared on address bits [51:28]. A committed window with base B and size S matches granule G when B <= G < B+S. The request goes to the window's target port, so only `fwd_valid[target]` rises.
- R3: Only windows with the commit bit set take part in decode. After reset every window is uncommitted, so every request is unrouted.
- R4: The write port selects a window with `cfg_idx` and a field with `cfg_field`: 0 = base, 1 = size, 2 = target, 3 = control. Bit 0 of control is the commit bit. Writes to base, size or target of a committed window are ignored. Control writes always take effect.
- R5: A request that matches no committed window raises `unrouted` for exactly one cycle. It raises no `fwd_valid` bit and needs no downstream ready.
- R6: Two windows with the same target and an unmapped gap between them route both regions to that target, and addresses in the gap are unrouted.
- R7: A request accepted on clock edge k shows its result (`fwd_valid` or `unrouted`) right after edge k.
- R8: While a forwarded request waits for `fwd_ready` of its port, `fwd_valid` and `fwd_addr` hold steady and `req_ready` stays low.
- R9: Out of reset, `req_ready` is high and no `fwd_valid` bit or `unrouted` is asserted.
- R10: A window whose end reaches the top of the 52-bit address space matches its highest address without wrap-around.
- R11: If misprogrammed windows overlap, the lowest-numbered matching window wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 2 | Window selected for the write |
| cfg_field | input | 2 | Field selected: 0 base, 1 size, 2 target, 3 control |
| cfg_wdata | input | 24 | Write data (granule count, port number, or commit in bit 0) |
| req_valid | input | 1 | Incoming request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 52 | Incoming request address |
| fwd_valid | output | 4 | Per-port forwarded request valid |
| fwd_ready | input | 4 | Per-port downstream ready |
| fwd_addr | output | 52 | Forwarded address, shared by all ports |
| unrouted | output | 1 | One-cycle flag for a request that hit no window |

## Verification
The routing function is driven with addresses at the first and last byte of each window and in the gap between two same-port windows. This separates an off-by-one end compare from a correct half-open one. Addresses beyond the last window and in a window at the top of the address space show whether the limit sum wraps. Requests sent before any commit, during a committed-window rewrite and after an uncommit tell commit gating apart from plain field writes. A stream of requests sent under a toggling per-port ready pattern, checked against a scoreboard, shows that ordering, held addresses and the stall of `req_ready` survive backpressure. A deliberately overlapping pair shows which entry has priority.

// File: rtl/arp_pkg.sv
package arp_pkg;
  typedef enum logic [1:0] {
    FLD_BASE   = 2'd0,
    FLD_SIZE   = 2'd1,
    FLD_TARGET = 2'd2,
    FLD_CTRL   = 2'd3
  } arp_field_e;

  function automatic int arp_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/arp_entry_bank.sv
module arp_entry_bank
  import arp_pkg::*;
#(
  parameter int N_ENTRY = 4,
  parameter int SLICE_W = 24,
  parameter int PORT_W  = 2,
  parameter int IDX_W   = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_we,
  input  logic [IDX_W-1:0]                  cfg_idx,
  input  arp_field_e                        cfg_field,
  input  logic [SLICE_W-1:0]                cfg_wdata,
  output logic [N_ENTRY-1:0][SLICE_W-1:0]   ent_base,
  output logic [N_ENTRY-1:0][SLICE_W-1:0]   ent_size,
  output logic [N_ENTRY-1:0][PORT_W-1:0]    ent_tgt,
  output logic [N_ENTRY-1:0]                ent_on
);
  for (genvar g = 0; g < N_ENTRY; g++) begin : g_ent
    logic               sel;
    logic               open_wr;
    logic               en;
    logic [SLICE_W-1:0] base_q, base_d;
    logic [SLICE_W-1:0] size_q, size_d;
    logic [PORT_W-1:0]  tgt_q, tgt_d;
    logic               on_q, on_d;

    assign sel     = cfg_we && (cfg_idx == IDX_W'(g));
    assign open_wr = sel && !on_q;

    always_comb begin
      base_d = base_q;
      size_d = size_q;
      tgt_d  = tgt_q;
      on_d   = on_q;
      if (sel && cfg_field == FLD_CTRL) on_d = cfg_wdata[0];
      if (open_wr && cfg_field == FLD_BASE)   base_d = cfg_wdata;
      if (open_wr && cfg_field == FLD_SIZE)   size_d = cfg_wdata;
      if (open_wr && cfg_field == FLD_TARGET) tgt_d  = cfg_wdata[PORT_W-1:0];
    end

    assign en = sel;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
        size_q <= '0;
        tgt_q  <= '0;
        on_q   <= 1'b0;
      end else if (en) begin
        base_q <= base_d;
        size_q <= size_d;
        tgt_q  <= tgt_d;
        on_q   <= on_d;
      end
    end

    assign ent_base[g] = base_q;
    assign ent_size[g] = size_q;
    assign ent_tgt[g]  = tgt_q;
    assign ent_on[g]   = on_q;
  end
endmodule

// File: rtl/arp_window_match.sv
module arp_window_match #(
  parameter int N_ENTRY = 4,
  parameter int SLICE_W = 24,
  parameter int PORT_W  = 2
) (
  input  logic [SLICE_W-1:0]                slice,
  input  logic [N_ENTRY-1:0][SLICE_W-1:0]   ent_base,
  input  logic [N_ENTRY-1:0][SLICE_W-1:0]   ent_size,
  input  logic [N_ENTRY-1:0][PORT_W-1:0]    ent_tgt,
  input  logic [N_ENTRY-1:0]                ent_on,
  output logic                              hit,
  output logic [PORT_W-1:0]                 hit_port
);
  logic [N_ENTRY-1:0] hit_vec;

  for (genvar g = 0; g < N_ENTRY; g++) begin : g_cmp
    logic [SLICE_W:0] lim;
    logic             above_base;
    logic             below_lim;
    assign lim        = {1'b0, ent_base[g]} + {1'b0, ent_size[g]};
    assign above_base = slice >= ent_base[g];
    assign below_lim  = {1'b0, slice} < lim;
    assign hit_vec[g] = ent_on[g] && above_base && below_lim;
  end

  always_comb begin
    hit      = 1'b0;
    hit_port = '0;
    for (int i = N_ENTRY - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit      = 1'b1;
        hit_port = ent_tgt[i];
      end
    end
  end
endmodule

// File: rtl/arp_out_stage.sv
module arp_out_stage #(
  parameter int ADDR_W = 52,
  parameter int N_PORT = 4,
  parameter int PORT_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc,
  input  logic [ADDR_W-1:0]   in_addr,
  input  logic                in_hit,
  input  logic [PORT_W-1:0]   in_port,
  input  logic [N_PORT-1:0]   fwd_ready,
  output logic [N_PORT-1:0]   fwd_valid,
  output logic [ADDR_W-1:0]   fwd_addr,
  output logic                unrouted,
  output logic                can_take
);
  logic              v_q, v_d;
  logic              miss_q, miss_d;
  logic [PORT_W-1:0] port_q, port_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              sel_ready;
  logic              drain;
  logic              en;

  always_comb begin
    sel_ready = 1'b0;
    for (int p = 0; p < N_PORT; p++) begin
      if (port_q == PORT_W'(p)) sel_ready = fwd_ready[p];
    end
  end

  assign drain    = v_q && (miss_q || sel_ready);
  assign can_take = !v_q || drain;
  assign en       = acc || drain;

  always_comb begin
    v_d    = v_q;
    miss_d = miss_q;
    port_d = port_q;
    addr_d = addr_q;
    if (acc) begin
      v_d    = 1'b1;
      miss_d = !in_hit;
      port_d = in_port;
      addr_d = in_addr;
    end else if (drain) begin
      v_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      miss_q <= 1'b0;
      port_q <= '0;
      addr_q <= '0;
    end else if (en) begin
      v_q    <= v_d;
      miss_q <= miss_d;
      port_q <= port_d;
      addr_q <= addr_d;
    end
  end

  for (genvar p = 0; p < N_PORT; p++) begin : g_fv
    assign fwd_valid[p] = v_q && !miss_q && (port_q == PORT_W'(p));
  end

  assign fwd_addr = addr_q;
  assign unrouted = v_q && miss_q;
endmodule

// File: rtl/addr_route_dec.sv
module addr_route_dec
  import arp_pkg::*;
#(
  parameter int ADDR_W   = 52,
  parameter int GRAN_LSB = 28,
  parameter int N_ENTRY  = 4,
  parameter int N_PORT   = 4,
  localparam int SLICE_W = ADDR_W - GRAN_LSB,
  localparam int IDX_W   = arp_width(N_ENTRY),
  localparam int PORT_W  = arp_width(N_PORT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic [1:0]          cfg_field,
  input  logic [SLICE_W-1:0]  cfg_wdata,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  output logic [N_PORT-1:0]   fwd_valid,
  input  logic [N_PORT-1:0]   fwd_ready,
  output logic [ADDR_W-1:0]   fwd_addr,
  output logic                unrouted
);
  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [N_ENTRY-1:0][SLICE_W-1:0] ent_base;
  logic [N_ENTRY-1:0][SLICE_W-1:0] ent_size;
  logic [N_ENTRY-1:0][PORT_W-1:0]  ent_tgt;
  logic [N_ENTRY-1:0]              ent_on;
  logic                            hit;
  logic [PORT_W-1:0]               hit_port;
  logic                            can_take;
  logic                            acc;

  arp_entry_bank #(
    .N_ENTRY(N_ENTRY), .SLICE_W(SLICE_W), .PORT_W(PORT_W), .IDX_W(IDX_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_sync_q),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_field(arp_field_e'(cfg_field)), .cfg_wdata(cfg_wdata),
    .ent_base(ent_base), .ent_size(ent_size), .ent_tgt(ent_tgt), .ent_on(ent_on)
  );

  arp_window_match #(
    .N_ENTRY(N_ENTRY), .SLICE_W(SLICE_W), .PORT_W(PORT_W)
  ) u_match (
    .slice(req_addr[ADDR_W-1:GRAN_LSB]),
    .ent_base(ent_base), .ent_size(ent_size), .ent_tgt(ent_tgt), .ent_on(ent_on),
    .hit(hit), .hit_port(hit_port)
  );

  assign req_ready = can_take && rst_sync_q;
  assign acc       = req_valid && req_ready;

  arp_out_stage #(
    .ADDR_W(ADDR_W), .N_PORT(N_PORT), .PORT_W(PORT_W)
  ) u_out (
    .clk(clk), .rst_n(rst_sync_q),
    .acc(acc), .in_addr(req_addr), .in_hit(hit), .in_port(hit_port),
    .fwd_ready(fwd_ready), .fwd_valid(fwd_valid), .fwd_addr(fwd_addr),
    .unrouted(unrouted), .can_take(can_take)
  );
endmodule

// File: rtl/arp_checker.sv
module arp_checker #(
  parameter int ADDR_W = 52,
  parameter int N_PORT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [N_PORT-1:0] fwd_valid,
  input logic [N_PORT-1:0] fwd_ready,
  input logic [ADDR_W-1:0] fwd_addr,
  input logic              unrouted
);
  // R2: a request goes to at most one port
  assert_fwd_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fwd_valid));

  // R5: an unrouted request is never forwarded
  assert_no_fwd_on_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    unrouted |-> (fwd_valid == '0));

  // R1: the accepted address reaches the output unchanged
  assert_addr_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (fwd_addr == $past(req_addr)));

  // R8: a stalled output holds
  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(fwd_valid & ~fwd_ready)) |=> ($stable(fwd_addr) && $stable(fwd_valid)));

  // R8: a stalled output blocks new requests
  assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(fwd_valid & ~fwd_ready)) |-> !req_ready);

  // R7: nothing appears without an accepted request
  assert_no_spont_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(req_valid && req_ready) && (fwd_valid == '0)) |=> ((fwd_valid == '0) && !unrouted));
endmodule

bind addr_route_dec arp_checker #(.ADDR_W(ADDR_W), .N_PORT(N_PORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .fwd_valid(fwd_valid), .fwd_ready(fwd_ready),
  .fwd_addr(fwd_addr), .unrouted(unrouted)
);

// File: tb/addr_route_dec_tb.sv
module addr_route_dec_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_idx;
  logic [1:0]  cfg_field;
  logic [23:0] cfg_wdata;
  logic        req_valid;
  logic        req_ready;
  logic [51:0] req_addr;
  logic [3:0]  fwd_valid;
  logic [3:0]  fwd_ready;
  logic [51:0] fwd_addr;
  logic        unrouted;

  always #5 clk = ~clk;

  addr_route_dec u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .fwd_valid(fwd_valid),
    .fwd_ready(fwd_ready), .fwd_addr(fwd_addr), .unrouted(unrouted)
  );

  int errors = 0;
  int checks = 0;
  bit mon_en = 1'b0;
  bit done   = 1'b0;

  longint m_base[4], m_size[4];
  int     m_tgt[4];
  bit     m_on[4];

  bit          q_miss[$];
  int          q_port[$];
  logic [51:0] q_addr[$];

  task automatic check(input string rq, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic wr(input int idx, input int fld, input longint data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_field = 2'(fld); cfg_wdata = 24'(data);
    @(negedge clk);
    cfg_we = 1'b0;
    if (fld == 3) m_on[idx] = data[0];
    else if (!m_on[idx]) begin
      if (fld == 0) m_base[idx] = data;
      if (fld == 1) m_size[idx] = data;
      if (fld == 2) m_tgt[idx]  = int'(data);
    end
  endtask

  function automatic void predict(input logic [51:0] a, output bit miss, output int port);
    longint g = longint'(a[51:28]);
    miss = 1'b1; port = 0;
    for (int i = 0; i < 4; i++) begin
      if (miss && m_on[i] && g >= m_base[i] && g < m_base[i] + m_size[i]) begin
        miss = 1'b0; port = m_tgt[i];
      end
    end
  endfunction

  task automatic send(input logic [51:0] a, input bit lat_chk);
    bit miss; int port; bit got;
    predict(a, miss, port);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    got = 1'b0;
    while (!got) begin
      #1 got = req_ready;
      @(posedge clk);
      if (!got) @(negedge clk);
    end
    q_miss.push_back(miss); q_port.push_back(port); q_addr.push_back(a);
    #1;
    if (lat_chk) check("R7 result visible one cycle after accept",
                       (fwd_valid != 0) || unrouted, longint'({fwd_valid, unrouted}), 1);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 50 && q_addr.size() != 0; i++) @(negedge clk);
    check("R8 all expected results delivered", q_addr.size() == 0, q_addr.size(), 0);
  endtask

  task automatic take(input bit miss, input int port);
    bit em; int ep; logic [51:0] ea;
    if (q_addr.size() == 0) begin
      check("R3 unexpected output", 1'b0, port, -1);
      return;
    end
    em = q_miss.pop_front(); ep = q_port.pop_front(); ea = q_addr.pop_front();
    if (em) check("R5 unrouted status", miss, miss, em);
    else begin
      check("R2 routed status", !miss, miss, em);
      if (!miss) check("R2 target port", port == ep, port, ep);
    end
    if (!miss) check("R1 forwarded address", fwd_addr == ea, fwd_addr, ea);
  endtask

  // monitor: results transfer on the next rising edge
  always @(negedge clk) begin
    #3;
    if (mon_en) begin
      for (int p = 0; p < 4; p++) if (fwd_valid[p] && fwd_ready[p]) take(1'b0, p);
      if (unrouted) take(1'b1, 0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check("watchdog expired", 1'b0, 0, 1);
      summary();
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_base[i] = 0; m_size[i] = 0; m_tgt[i] = 0; m_on[i] = 0; end
    rst_n = 1'b0; cfg_we = 0; cfg_idx = 0; cfg_field = 0; cfg_wdata = 0;
    req_valid = 0; req_addr = 0; fwd_ready = 4'hF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check("R9 req_ready after reset", req_ready == 1'b1, req_ready, 1);
    check("R9 no forward after reset", fwd_valid == 4'h0, fwd_valid, 0);
    check("R9 no unrouted after reset", unrouted == 1'b0, unrouted, 0);
    mon_en = 1'b1;

    // R3: nothing committed yet
    send(52'h1_0000_0000, 1'b1);
    send(52'h1_2345_6789, 1'b1);

    // R2, R6: two adjacent ports, plus a split pair on port 2
    wr(0, 0, 24'h10); wr(0, 1, 1); wr(0, 2, 0); wr(0, 3, 1);
    wr(1, 0, 24'h11); wr(1, 1, 1); wr(1, 2, 1); wr(1, 3, 1);
    wr(2, 0, 24'h20); wr(2, 1, 1); wr(2, 2, 2); wr(2, 3, 1);
    wr(3, 0, 24'h22); wr(3, 1, 2); wr(3, 2, 2); wr(3, 3, 1);
    send(52'h1_0123_4567, 1'b1);
    send(52'h1_0FFF_FFFF, 1'b1);
    send(52'h1_1000_0000, 1'b1);
    send(52'h1_2000_0000, 1'b1);
    send(52'h2_0000_0000, 1'b1);
    send(52'h2_1000_0000, 1'b1); // R6 gap
    send(52'h2_2000_0000, 1'b1);
    send(52'h2_3FFF_FFFF, 1'b1);
    send(52'h2_4000_0000, 1'b1);
    drain();

    // R4: rewrite of a committed window is ignored
    wr(0, 0, 24'h30); wr(0, 2, 3);
    send(52'h1_0000_0040, 1'b1);
    send(52'h3_0000_0000, 1'b1);
    // R4: uncommit, reprogram, recommit
    wr(1, 3, 0);
    send(52'h1_1000_0000, 1'b1);
    wr(1, 0, 24'h30); wr(1, 2, 3); wr(1, 3, 1);
    send(52'h3_0000_0005, 1'b1);
    drain();

    // R10: window at the top of the address space
    wr(3, 3, 0); wr(3, 0, 24'hFF_FFFF); wr(3, 1, 1); wr(3, 2, 1); wr(3, 3, 1);
    send(52'hF_FFFF_FFFF_FFFF, 1'b1);
    send(52'h0_0000_0000_0000, 1'b1);
    drain();

    // R11: overlap, lowest index wins
    wr(2, 3, 0); wr(2, 0, 24'h30); wr(2, 2, 2); wr(2, 3, 1);
    send(52'h3_0800_0000, 1'b1);
    drain();

    // R8: stall on port 0
    @(negedge clk); fwd_ready = 4'b1110;
    send(52'h1_0000_1000, 1'b0);
    repeat (3) @(negedge clk);
    #1;
    check("R8 stalled valid held", fwd_valid == 4'b0001, fwd_valid, 1);
    check("R8 stalled address held", fwd_addr == 52'h1_0000_1000, fwd_addr, 52'h1_0000_1000);
    check("R8 req_ready low while stalled", req_ready == 1'b0, req_ready, 0);
    @(negedge clk); fwd_ready = 4'hF;
    drain();

    // R8: stream under a toggling ready pattern
    fork
      begin
        for (int c = 0; c < 60; c++) begin
          @(negedge clk);
          fwd_ready = 4'((c * 5 + 3) % 16) | 4'((c % 3 == 0) ? 4'hF : 4'h0);
        end
        @(negedge clk); fwd_ready = 4'hF;
      end
      begin
        send(52'h1_0000_0100, 1'b0);
        send(52'h3_0000_0200, 1'b0);
        send(52'h2_0000_0300, 1'b0);
        send(52'h2_1000_0400, 1'b0);
        send(52'hF_FFFF_0000_0500, 1'b0);
        send(52'h1_0000_0600, 1'b0);
        send(52'h3_1000_0700, 1'b0);
        send(52'h2_0FFF_0800, 1'b0);
      end
    join
    drain();

    done = 1'b1;
    summary();
  end
endmodule